// File: doc/BRIEF.md
# Register Write-Hazard Scoreboard

This block keeps one bit per architectural register that marks a result still in flight. When an instruction that writes a destination register is issued, the bit for that register goes high. When the register-file write for that register is granted, the bit goes low again. Read-side logic can then see which registers must not be read yet.

The block has two update ports. The set port serves the issuing units. The clear port serves the register-file write arbiters. Each port takes several requesters, and their masks are ORed together. A parameter chooses, per requester, whether the request value is a one-hot mask used as it is or a binary register number that is decoded to one bit. The block drives the whole vector out and also answers a single-register query combinationally. If the same bit is set and cleared in one cycle, the set wins, so a fresh issue is never lost.

Top module: `hzd_scoreboard`

## Requirements
- R1: While rst_ni is low, every bit of vec_o is 0, and qry_hit_o is 0 for every index.
- R2: A set requester whose set_issue_i, set_sel_i and set_wflag_i are all 1 at a rising clock edge makes its target bits read 1 on vec_o after that edge.
- R3: A set requester with any one of set_issue_i, set_sel_i or set_wflag_i at 0 changes no bit of vec_o.
- R4: A requester in binary mode (its bit in SET_UNARY or CLR_UNARY is 0) addresses only the single register whose number is in the low log2(NUM_REGS) bits of its value field.
- R5: A requester in unary mode (its bit in SET_UNARY or CLR_UNARY is 1) uses its whole value field as the bit mask, so several registers can be addressed at once.
- R6: A clear requester acts only in the cycle where clr_grant_i rises from 0 to 1. Holding the grant high clears nothing more, so a bit that is set again while the grant stays high stays at 1.
- R7: The masks of all requesters on one port are ORed together, so different requesters act on different bits in the same cycle.
- R8: If a bit is both set and cleared in the same cycle, it reads 1 afterwards.
- R9: qry_hit_o is the current value of vec_o at bit qry_idx_i, with no clock delay.
- R10: A bit that is neither set nor cleared in a cycle keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_issue_i | input | N_SET | Per set requester: the unit is issuing |
| set_sel_i | input | N_SET | Per set requester: the unit is the selected one |
| set_wflag_i | input | N_SET | Per set requester: the instruction writes on this port |
| set_val_i | input | N_SET*NUM_REGS | Per set requester: binary number or one-hot mask, requester k at bits k*NUM_REGS upward |
| clr_grant_i | input | N_CLR | Per clear requester: write grant level from the arbiter |
| clr_val_i | input | N_CLR*NUM_REGS | Per clear requester: binary number or one-hot mask |
| qry_idx_i | input | IDXW | Register number to query |
| qry_hit_o | output | 1 | Hazard bit of the queried register |
| vec_o | output | NUM_REGS | Full hazard vector |

## Verification
The assertions assume that rst_ni is held low across at least one clock edge at start-up, and that each grant input is a clean level that changes only between edges. Given that, the set and clear masks account for every change of the vector. The bench drives all inputs at the falling edge and pulls reset low from time zero. It uses binary numbers and unary masks that overlap on a small register range, so the random phase produces frequent same-register collisions between set and clear, and between requesters on the same port.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic {
    ADDR_BIN   = 1'b0,
    ADDR_UNARY = 1'b1
  } addr_mode_e;

  function automatic int idx_w(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/hzd_addr_dec.sv
module hzd_addr_dec
  import hzd_pkg::*;
#(
  parameter int         NUM_REGS = 32,
  parameter addr_mode_e MODE     = ADDR_BIN,
  localparam int        IDXW     = idx_w(NUM_REGS)
) (
  input  logic                en_i,
  input  logic [NUM_REGS-1:0] val_i,
  output logic [NUM_REGS-1:0] mask_o
);
  generate
    if (MODE == ADDR_UNARY) begin : g_unary
      assign mask_o = en_i ? val_i : '0;
    end else begin : g_bin
      logic [NUM_REGS-1:0] one_hot;
      logic                unused_hi;
      assign unused_hi = ^val_i[NUM_REGS-1:IDXW];
      always_comb begin
        one_hot = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
          if (val_i[IDXW-1:0] == IDXW'(r)) one_hot[r] = 1'b1;
        end
      end
      assign mask_o = en_i ? one_hot : '0;
    end
  endgenerate
endmodule

// File: rtl/hzd_edge_pulse.sv
module hzd_edge_pulse #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] pulse_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign pulse_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/hzd_or_merge.sv
module hzd_or_merge #(
  parameter int N = 2,
  parameter int W = 32
) (
  input  logic [N*W-1:0] in_i,
  output logic [W-1:0]   out_o
);
  always_comb begin
    out_o = '0;
    for (int k = 0; k < N; k++) out_o = out_o | in_i[k*W +: W];
  end
endmodule

// File: rtl/hzd_scoreboard.sv
module hzd_scoreboard
  import hzd_pkg::*;
#(
  parameter int             NUM_REGS  = 32,
  parameter int             N_SET     = 2,
  parameter int             N_CLR     = 2,
  parameter bit [N_SET-1:0] SET_UNARY = 2'b10,
  parameter bit [N_CLR-1:0] CLR_UNARY = 2'b01,
  localparam int            IDXW      = idx_w(NUM_REGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_SET-1:0]          set_issue_i,
  input  logic [N_SET-1:0]          set_sel_i,
  input  logic [N_SET-1:0]          set_wflag_i,
  input  logic [N_SET*NUM_REGS-1:0] set_val_i,
  input  logic [N_CLR-1:0]          clr_grant_i,
  input  logic [N_CLR*NUM_REGS-1:0] clr_val_i,
  input  logic [IDXW-1:0]           qry_idx_i,
  output logic                      qry_hit_o,
  output logic [NUM_REGS-1:0]       vec_o
);
  logic [N_SET-1:0]          set_en;
  logic [N_CLR-1:0]          clr_pulse;
  logic [N_SET*NUM_REGS-1:0] set_req;
  logic [N_CLR*NUM_REGS-1:0] clr_req;
  logic [NUM_REGS-1:0]       set_mask;
  logic [NUM_REGS-1:0]       clr_mask;
  logic [NUM_REGS-1:0]       vec_q;

  // set request: issuing, selected, and writing on this port
  assign set_en = set_issue_i & set_sel_i & set_wflag_i;

  hzd_edge_pulse #(.N(N_CLR)) u_grant_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (clr_grant_i),
    .pulse_o(clr_pulse)
  );

  generate
    for (genvar k = 0; k < N_SET; k++) begin : g_set
      hzd_addr_dec #(
        .NUM_REGS(NUM_REGS),
        .MODE    (SET_UNARY[k] ? ADDR_UNARY : ADDR_BIN)
      ) u_dec (
        .en_i  (set_en[k]),
        .val_i (set_val_i[k*NUM_REGS +: NUM_REGS]),
        .mask_o(set_req[k*NUM_REGS +: NUM_REGS])
      );
    end
    for (genvar k = 0; k < N_CLR; k++) begin : g_clr
      hzd_addr_dec #(
        .NUM_REGS(NUM_REGS),
        .MODE    (CLR_UNARY[k] ? ADDR_UNARY : ADDR_BIN)
      ) u_dec (
        .en_i  (clr_pulse[k]),
        .val_i (clr_val_i[k*NUM_REGS +: NUM_REGS]),
        .mask_o(clr_req[k*NUM_REGS +: NUM_REGS])
      );
    end
  endgenerate

  hzd_or_merge #(.N(N_SET), .W(NUM_REGS)) u_set_merge (
    .in_i (set_req),
    .out_o(set_mask)
  );

  hzd_or_merge #(.N(N_CLR), .W(NUM_REGS)) u_clr_merge (
    .in_i (clr_req),
    .out_o(clr_mask)
  );

  // set after clear: same-cycle collision keeps the new issue
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vec_q <= '0;
    else         vec_q <= (vec_q & ~clr_mask) | set_mask;
  end

  assign vec_o     = vec_q;
  assign qry_hit_o = (int'(qry_idx_i) < NUM_REGS) ? vec_q[qry_idx_i] : 1'b0;
endmodule

// File: rtl/hzd_scoreboard_chk.sv
module hzd_scoreboard_chk #(
  parameter int NUM_REGS = 32,
  parameter int N_CLR    = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_REGS-1:0] set_mask,
  input logic [NUM_REGS-1:0] clr_mask,
  input logic [N_CLR-1:0]    clr_pulse,
  input logic [N_CLR-1:0]    clr_grant_i,
  input logic [NUM_REGS-1:0] vec_o
);
  assert_set_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_mask) |=> ((vec_o & $past(set_mask)) == $past(set_mask)));

  assert_clear_lands_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_mask & ~set_mask)) |=> ((vec_o & $past(clr_mask & ~set_mask)) == '0));

  assert_pulse_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_pulse) |=> ((clr_pulse & $past(clr_pulse)) == '0));

  assert_pulse_needs_grant_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_pulse & ~clr_grant_i) == '0));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((vec_o & ~$past(set_mask | clr_mask)) == ($past(vec_o) & ~$past(set_mask | clr_mask))));
endmodule

bind hzd_scoreboard hzd_scoreboard_chk #(
  .NUM_REGS(NUM_REGS),
  .N_CLR   (N_CLR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .set_mask   (set_mask),
  .clr_mask   (clr_mask),
  .clr_pulse  (clr_pulse),
  .clr_grant_i(clr_grant_i),
  .vec_o      (vec_o)
);

// File: tb/tb_hzd_scoreboard.sv
module tb_hzd_scoreboard;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 32;
  localparam int NS = 2;
  localparam int NC = 2;
  localparam bit [NS-1:0] SET_U = 2'b10;
  localparam bit [NC-1:0] CLR_U = 2'b01;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NS-1:0]     set_issue = '0, set_sel = '0, set_wflag = '0;
  logic [NS*NR-1:0]  set_val = '0;
  logic [NC-1:0]     clr_grant = '0;
  logic [NC*NR-1:0]  clr_val = '0;
  logic [4:0]        qry_idx = '0;
  logic              qry_hit;
  logic [NR-1:0]     vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [NR-1:0] ref_vec = '0;
  logic [NC-1:0] ref_gprev = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hzd_scoreboard #(
    .NUM_REGS(NR), .N_SET(NS), .N_CLR(NC), .SET_UNARY(SET_U), .CLR_UNARY(CLR_U)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .set_issue_i(set_issue), .set_sel_i(set_sel), .set_wflag_i(set_wflag), .set_val_i(set_val),
    .clr_grant_i(clr_grant), .clr_val_i(clr_val),
    .qry_idx_i(qry_idx), .qry_hit_o(qry_hit), .vec_o(vec)
  );

  function automatic logic [NR-1:0] mask_of(bit unary, logic [NR-1:0] v);
    return unary ? v : (NR'(1) << v[4:0]);
  endfunction

  task automatic check_vec(string tag);
    checks++;
    if (vec !== ref_vec) begin
      errors++;
      $display("FAIL %s vec actual=%h expected=%h", tag, vec, ref_vec);
    end
    for (int q = 0; q < 3; q++) begin
      qry_idx = (q == 0) ? 5'($urandom_range(0, 31)) : 5'($urandom_range(0, 12));
      #1;
      checks++;
      if (qry_hit !== ref_vec[qry_idx]) begin
        errors++;
        $display("FAIL R9 (%s) qry idx=%0d actual=%b expected=%b", tag, qry_idx, qry_hit, ref_vec[qry_idx]);
      end
    end
  endtask

  // one clock: model the edge, then compare at the falling edge
  task automatic step(string tag);
    logic [NR-1:0] sm, cm;
    sm = '0;
    cm = '0;
    for (int k = 0; k < NS; k++)
      if (set_issue[k] && set_sel[k] && set_wflag[k])
        sm |= mask_of(SET_U[k], set_val[k*NR +: NR]);
    for (int k = 0; k < NC; k++)
      if (clr_grant[k] && !ref_gprev[k])
        cm |= mask_of(CLR_U[k], clr_val[k*NR +: NR]);
    @(posedge clk);
    ref_vec = (ref_vec & ~cm) | sm;
    ref_gprev = clr_grant;
    @(negedge clk);
    check_vec(tag);
  endtask

  task automatic idle();
    set_issue = '0; set_sel = '0; set_wflag = '0;
  endtask

  task automatic set_req(int k, logic [NR-1:0] v);
    set_issue[k] = 1'b1; set_sel[k] = 1'b1; set_wflag[k] = 1'b1;
    set_val[k*NR +: NR] = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_vec("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R4: binary requester 0, register 5
    set_req(0, NR'(5));
    step("R2 R4 binary set");
    idle();

    // R3: one enable low each time
    set_req(0, NR'(7)); set_sel[0] = 1'b0;   step("R3 sel low");
    set_req(0, NR'(7)); set_issue[0] = 1'b0; step("R3 issue low");
    set_req(0, NR'(7)); set_wflag[0] = 1'b0; step("R3 wflag low");
    idle();

    // R5: unary requester 1, two bits
    set_req(1, 32'h0000_0300);
    step("R5 unary set");
    idle();

    // R7: both set requesters together
    set_req(0, NR'(12)); set_req(1, 32'h0010_0000);
    step("R7 set merge");
    idle();

    // R6: rising grant on binary clear requester 1 clears bit 5
    clr_val[NR +: NR] = NR'(5); clr_grant[1] = 1'b1;
    step("R6 clear on rise");
    set_req(0, NR'(5));
    step("R6 reset while grant high");
    idle();
    step("R6 held grant no clear");
    step("R10 hold");
    clr_grant[1] = 1'b0;
    step("R6 grant low");

    // R7: both clear requesters together
    clr_val[0 +: NR] = 32'h0000_0300; clr_val[NR +: NR] = NR'(12);
    clr_grant = 2'b11;
    step("R7 clear merge");
    clr_grant = 2'b00;
    step("R10 idle");

    // R8: set and clear on bit 20 (already 1) and bit 21 (was 0)
    set_req(0, NR'(20)); set_req(1, 32'h0020_0000);
    clr_val[0 +: NR] = 32'h0020_0000; clr_val[NR +: NR] = NR'(20);
    clr_grant = 2'b11;
    step("R8 set wins");
    idle(); clr_grant = 2'b00;
    step("R8 after");

    // R4: binary value with high bits set uses only the low field
    set_req(0, 32'hFFFF_FFE3);
    step("R4 high bits ignored");
    idle();

    // random phase over a small register range for collisions
    for (int n = 0; n < 3000; n++) begin
      for (int k = 0; k < NS; k++) begin
        set_issue[k] = ($urandom_range(0, 3) != 0);
        set_sel[k]   = ($urandom_range(0, 3) != 0);
        set_wflag[k] = ($urandom_range(0, 3) != 0);
        set_val[k*NR +: NR] = SET_U[k] ?
          ((NR'(1) << $urandom_range(0, 7)) | (NR'(1) << $urandom_range(0, 7))) :
          NR'($urandom_range(0, 7));
      end
      for (int k = 0; k < NC; k++) begin
        if ($urandom_range(0, 2) == 0) clr_grant[k] = ~clr_grant[k];
        clr_val[k*NR +: NR] = CLR_U[k] ?
          ((NR'(1) << $urandom_range(0, 7)) | (NR'(1) << $urandom_range(0, 7))) :
          NR'($urandom_range(0, 7));
      end
      step("R2 R6 R7 R8 R10 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule